// File: doc/BRIEF.md
# Interrupt Controller Register File

This block keeps every register that software sees in a multi-input interrupt controller. It sits behind a plain 32-bit word bus with a request strobe, a write flag, a byte address, byte enables, write data, combinational read data and an error flag. A detection stage in front of it delivers one capture pulse per input. A priority stage behind it returns the vector of the best enabled interrupt. The block holds the status bits and the enable bits. It drives the enabled-and-pending vector toward the priority and request logic, and it drives the master enable.

Software first runs with hardware inputs shut off. In that phase it can raise interrupts by writing the status register, which is useful for self-test. Writing the hardware-enable bit ends that phase for good, up to the next reset. Enables can be rewritten whole, or changed one bit at a time through a set-only location and a clear-only location. Captured interrupts stay latched until software acknowledges them.

Top module: `intc_regfile`

## Requirements
- R1: Word slots are decoded from address bits [4:2]: status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18, master 0x1C. The three write-only slots (0x0C, 0x10, 0x14) read as zero.
- R2: After reset, status, enable, pending and master read zero and the vector slot reads all ones.
- R3: While the hardware-enable bit is 0, each 1 written to status sets that status bit, and capture pulses are ignored.
- R4: Once the hardware-enable bit is 1, writes to status change nothing, and each capture pulse sets its status bit on the next clock.
- R5: Each 1 written to acknowledge clears that status bit. A 0 written there changes nothing.
- R6: When a capture pulse and an acknowledge hit the same status bit in one cycle, the bit ends up set.
- R7: Pending reads as status AND enable. Writes to 0x04 change no register.
- R8: A 1 written to set-enable sets that enable bit, and a 1 written to clear-enable clears it. Other enable bits are unchanged. Clearing an enable leaves the status bit latched.
- R9: The master slot reads {30'b0, hw_enable, master_enable}, with the master enable at bit 0 and the hardware enable at bit 1. master_en_o follows bit 0 one clock after the write.
- R10: The hardware-enable bit can only go from 0 to 1. A written 0 does not clear it; only reset does.
- R11: Bits at or above NUM_IN read as zero, and writes to them are ignored.
- R12: An access with any byte enable low, or with address bits [1:0] nonzero, raises bus_err in the same cycle, reads zero and changes no register. Full-word aligned accesses never raise bus_err.
- R13: The vector slot returns vec_i as it was one clock earlier. Writes to it are ignored.
- R14: pend_o always equals the pending value, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address inside the block |
| bus_be | input | 4 | Byte enables; all must be high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| bus_err | output | 1 | Error response for partial or misaligned access |
| cap_i | input | NUM_IN | Capture pulses from the detection stage |
| vec_i | input | 32 | Vector from the priority stage |
| pend_o | output | NUM_IN | Enabled pending interrupts |
| master_en_o | output | 1 | Master request enable |

## Verification
The bench targets the handover of the hardware-enable bit. A design that let captures in too early would show status bits appearing before the handover. A design that kept accepting software writes afterwards would show bits that no capture caused. A design that let a written 0 clear the bit would fail both checks. The bench also drives a capture and an acknowledge on the same bit in one cycle. An acknowledge that wins there would lose the interrupt. Partial and misaligned writes are sent to the enable slot, where a design that only flagged the error but still stored the data would show a changed enable. The bench disables an interrupt while it is pending and then reads status, which catches a design that treats a cleared enable as an acknowledge.

// File: rtl/intc_rf_pkg.sv
package intc_rf_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned BE_W   = REG_W / 8;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned SLOT_N = 8;

    // word slot selected by address bits [4:2]
    typedef enum logic [2:0] {
        SLOT_STATUS = 3'd0,
        SLOT_PEND   = 3'd1,
        SLOT_EN     = 3'd2,
        SLOT_ACK    = 3'd3,
        SLOT_SETEN  = 3'd4,
        SLOT_CLREN  = 3'd5,
        SLOT_VEC    = 3'd6,
        SLOT_MASTER = 3'd7
    } slot_e;

    typedef struct packed {
        logic hw_en;
        logic mst_en;
    } master_t;

endpackage

// File: rtl/intc_rf_decode.sv
module intc_rf_decode
    import intc_rf_pkg::*;
(
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BE_W-1:0]     bus_be,
    output logic [SLOT_N-1:0]   wr_sel,
    output slot_e               rd_slot,
    output logic                rd_ok,
    output logic                err
);

    logic good;

    always_comb begin
        good    = (&bus_be) && (bus_addr[1:0] == 2'b00);
        rd_slot = slot_e'(bus_addr[ADDR_W-1:2]);
        err     = bus_req && !good;
        rd_ok   = bus_req && !bus_we && good;
        wr_sel  = '0;
        if (bus_req && bus_we && good) begin
            wr_sel[bus_addr[ADDR_W-1:2]] = 1'b1;
        end
    end

endmodule

// File: rtl/intc_rf_status.sv
module intc_rf_status
    import intc_rf_pkg::*;
#(
    parameter int unsigned NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              sts_we,
    input  logic              ack_we,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NUM_IN-1:0] cap,
    output logic [NUM_IN-1:0] sts_o
);

    typedef struct packed {
        logic [NUM_IN-1:0] sts;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_we) begin
            st_d.sts = st_d.sts & ~NUM_IN'(wdata);
        end
        if (!hw_en && sts_we) begin
            st_d.sts = st_d.sts | NUM_IN'(wdata);
        end
        if (hw_en) begin
            st_d.sts = st_d.sts | cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;

    // R6
    cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && (|cap)) |=> ((sts_o & $past(cap)) == $past(cap)));

    // R3
    hw_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_en && !sts_we && !ack_we) |=> $stable(sts_o));

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !hw_en) |=> ((sts_o & $past(NUM_IN'(wdata))) == '0));

endmodule

// File: rtl/intc_rf_enable.sv
module intc_rf_enable
    import intc_rf_pkg::*;
#(
    parameter int unsigned NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [REG_W-1:0]  wdata,
    output logic [NUM_IN-1:0] en_o
);

    typedef struct packed {
        logic [NUM_IN-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;
    logic [NUM_IN-1:0] msk;

    always_comb begin
        msk  = NUM_IN'(wdata);
        st_d = st_q;
        if (en_we) begin
            st_d.en = msk;
        end
        if (set_we) begin
            st_d.en = st_d.en | msk;
        end
        if (clr_we) begin
            st_d.en = st_d.en & ~msk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    // R8
    set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (((en_o & $past(msk)) == $past(msk)) &&
                    ((en_o & ~$past(msk)) == ($past(en_o) & ~$past(msk)))));

    // R8
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (((en_o & $past(msk)) == '0) &&
                    ((en_o & ~$past(msk)) == ($past(en_o) & ~$past(msk)))));

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_rf_pkg::*;
#(
    parameter int unsigned NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [NUM_IN-1:0] cap_i,
    input  logic [REG_W-1:0]  vec_i,
    output logic [NUM_IN-1:0] pend_o,
    output logic              master_en_o
);

    typedef struct packed {
        master_t          mst;
        logic [REG_W-1:0] vec;
    } top_state_t;

    logic [SLOT_N-1:0] wr_sel;
    slot_e             rd_slot;
    logic              rd_ok;
    logic [NUM_IN-1:0] sts;
    logic [NUM_IN-1:0] en;
    logic [NUM_IN-1:0] pend;
    top_state_t        st_d, st_q;

    intc_rf_decode i_decode (
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .wr_sel   (wr_sel),
        .rd_slot  (rd_slot),
        .rd_ok    (rd_ok),
        .err      (bus_err)
    );

    intc_rf_status #(.NUM_IN(NUM_IN)) i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_en  (st_q.mst.hw_en),
        .sts_we (wr_sel[SLOT_STATUS]),
        .ack_we (wr_sel[SLOT_ACK]),
        .wdata  (bus_wdata),
        .cap    (cap_i),
        .sts_o  (sts)
    );

    intc_rf_enable #(.NUM_IN(NUM_IN)) i_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_we  (wr_sel[SLOT_EN]),
        .set_we (wr_sel[SLOT_SETEN]),
        .clr_we (wr_sel[SLOT_CLREN]),
        .wdata  (bus_wdata),
        .en_o   (en)
    );

    always_comb begin
        st_d         = st_q;
        st_d.vec     = vec_i;
        if (wr_sel[SLOT_MASTER]) begin
            st_d.mst.mst_en = bus_wdata[0];
            st_d.mst.hw_en  = st_q.mst.hw_en | bus_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mst <= '0;
            st_q.vec <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pend      = sts & en;
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (rd_slot)
                SLOT_STATUS: bus_rdata = REG_W'(sts);
                SLOT_PEND:   bus_rdata = REG_W'(pend);
                SLOT_EN:     bus_rdata = REG_W'(en);
                SLOT_VEC:    bus_rdata = st_q.vec;
                SLOT_MASTER: bus_rdata = REG_W'(st_q.mst);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign pend_o      = pend;
    assign master_en_o = st_q.mst.mst_en;

    // R10
    hw_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mst.hw_en |=> st_q.mst.hw_en);

    // R12
    err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !st_q.mst.hw_en) |=> ($stable(sts) && $stable(en) && $stable(st_q.mst)));

    // R12
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> ($stable(en) && $stable(st_q.mst)));

    // R9
    mst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[SLOT_MASTER] |=> (master_en_o == $past(bus_wdata[0])));

endmodule

// File: tb/test_intc_regfile.sv
module test_intc_regfile;

    localparam int unsigned NI = 8;
    localparam logic [1:0] K_IDLE = 2'd0;
    localparam logic [1:0] K_WR   = 2'd1;
    localparam logic [1:0] K_RD   = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [7:0]  cap;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  rq;
    } step_t;

    localparam int NSTEP = 47;
    localparam step_t STEPS [NSTEP] = '{
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0,         1'b0, 8'd2},  // R2
        '{K_RD,   5'h08, 4'hF, 32'h0,         8'h00, 32'h0,         1'b0, 8'd2},  // R2
        '{K_RD,   5'h1C, 4'hF, 32'h0,         8'h00, 32'h0,         1'b0, 8'd2},  // R2
        '{K_RD,   5'h04, 4'hF, 32'h0,         8'h00, 32'h0,         1'b0, 8'd2},  // R2
        '{K_WR,   5'h00, 4'hF, 32'h0000_0105, 8'h00, 32'h0,         1'b0, 8'd3},  // R3
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0005, 1'b0, 8'd11}, // R11
        '{K_WR,   5'h08, 4'hF, 32'hFFFF_FF03, 8'h00, 32'h0,         1'b0, 8'd1},  // R1
        '{K_RD,   5'h08, 4'hF, 32'h0,         8'h00, 32'h0000_0003, 1'b0, 8'd11}, // R11
        '{K_RD,   5'h04, 4'hF, 32'h0,         8'h00, 32'h0000_0001, 1'b0, 8'd7},  // R7
        '{K_IDLE, 5'h00, 4'hF, 32'h0,         8'h80, 32'h0,         1'b0, 8'd3},  // R3
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0005, 1'b0, 8'd3},  // R3
        '{K_WR,   5'h10, 4'hF, 32'h0000_0104, 8'h00, 32'h0,         1'b0, 8'd8},  // R8
        '{K_RD,   5'h08, 4'hF, 32'h0,         8'h00, 32'h0000_0007, 1'b0, 8'd8},  // R8
        '{K_WR,   5'h14, 4'hF, 32'h0000_0001, 8'h00, 32'h0,         1'b0, 8'd8},  // R8
        '{K_RD,   5'h08, 4'hF, 32'h0,         8'h00, 32'h0000_0006, 1'b0, 8'd8},  // R8
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0005, 1'b0, 8'd8},  // R8
        '{K_RD,   5'h04, 4'hF, 32'h0,         8'h00, 32'h0000_0004, 1'b0, 8'd7},  // R7
        '{K_WR,   5'h0C, 4'hF, 32'h0000_0004, 8'h00, 32'h0,         1'b0, 8'd5},  // R5
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0001, 1'b0, 8'd5},  // R5
        '{K_WR,   5'h0C, 4'hF, 32'h0000_0000, 8'h00, 32'h0,         1'b0, 8'd5},  // R5
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0001, 1'b0, 8'd5},  // R5
        '{K_RD,   5'h0C, 4'hF, 32'h0,         8'h00, 32'h0,         1'b0, 8'd1},  // R1
        '{K_RD,   5'h10, 4'hF, 32'h0,         8'h00, 32'h0,         1'b0, 8'd1},  // R1
        '{K_RD,   5'h14, 4'hF, 32'h0,         8'h00, 32'h0,         1'b0, 8'd1},  // R1
        '{K_WR,   5'h1C, 4'hF, 32'hFFFF_FFFF, 8'h00, 32'h0,         1'b0, 8'd9},  // R9
        '{K_RD,   5'h1C, 4'hF, 32'h0,         8'h00, 32'h0000_0003, 1'b0, 8'd9},  // R9
        '{K_WR,   5'h1C, 4'hF, 32'h0000_0000, 8'h00, 32'h0,         1'b0, 8'd10}, // R10
        '{K_RD,   5'h1C, 4'hF, 32'h0,         8'h00, 32'h0000_0002, 1'b0, 8'd10}, // R10
        '{K_WR,   5'h00, 4'hF, 32'h0000_00F0, 8'h00, 32'h0,         1'b0, 8'd4},  // R4
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0001, 1'b0, 8'd4},  // R4
        '{K_IDLE, 5'h00, 4'hF, 32'h0,         8'h30, 32'h0,         1'b0, 8'd4},  // R4
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0031, 1'b0, 8'd4},  // R4
        '{K_WR,   5'h0C, 4'hF, 32'h0000_0010, 8'h10, 32'h0,         1'b0, 8'd6},  // R6
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0031, 1'b0, 8'd6},  // R6
        '{K_WR,   5'h0C, 4'hF, 32'h0000_0021, 8'h00, 32'h0,         1'b0, 8'd5},  // R5
        '{K_RD,   5'h00, 4'hF, 32'h0,         8'h00, 32'h0000_0010, 1'b0, 8'd5},  // R5
        '{K_WR,   5'h08, 4'h3, 32'h0000_00FF, 8'h00, 32'h0,         1'b1, 8'd12}, // R12
        '{K_RD,   5'h08, 4'hF, 32'h0,         8'h00, 32'h0000_0006, 1'b0, 8'd12}, // R12
        '{K_RD,   5'h00, 4'h1, 32'h0,         8'h00, 32'h0,         1'b1, 8'd12}, // R12
        '{K_WR,   5'h09, 4'hF, 32'h0000_00FF, 8'h00, 32'h0,         1'b1, 8'd12}, // R12
        '{K_RD,   5'h08, 4'hF, 32'h0,         8'h00, 32'h0000_0006, 1'b0, 8'd12}, // R12
        '{K_WR,   5'h10, 4'hF, 32'h0000_0010, 8'h00, 32'h0,         1'b0, 8'd8},  // R8
        '{K_WR,   5'h04, 4'hF, 32'h0000_00FF, 8'h00, 32'h0,         1'b0, 8'd7},  // R7
        '{K_RD,   5'h04, 4'hF, 32'h0,         8'h00, 32'h0000_0010, 1'b0, 8'd7},  // R7
        '{K_RD,   5'h08, 4'hF, 32'h0,         8'h00, 32'h0000_0016, 1'b0, 8'd7},  // R7
        '{K_WR,   5'h18, 4'hF, 32'h0000_0000, 8'h00, 32'h0,         1'b0, 8'd13}, // R13
        '{K_RD,   5'h18, 4'hF, 32'h0,         8'h00, 32'hFFFF_FFFF, 1'b0, 8'd13}  // R13
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [3:0]    bus_be = 4'hF;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err;
    logic [NI-1:0] cap_i = '0;
    logic [31:0]   vec_i = 32'h0000_0005;
    logic [NI-1:0] pend_o;
    logic          master_en_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intc_regfile #(.NUM_IN(NI)) i_intc_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_be      (bus_be),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .cap_i       (cap_i),
        .vec_i       (vec_i),
        .pend_o      (pend_o),
        .master_en_o (master_en_o)
    );

    task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic access(input logic we, input logic [4:0] a, input logic [3:0] be,
                          input logic [31:0] d);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_req = 1'b0;
        bus_we  = 1'b0;
        cap_i   = '0;
    endtask

    initial begin
        // reset values, vector tracking
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 5'h18; bus_be = 4'hF;
        #2;
        check(2, bus_rdata, 32'hFFFF_FFFF);              // R2 vector reset
        check(14, 32'(pend_o), 32'h0);                   // R14
        check(9, 32'(master_en_o), 32'h0);               // R9
        @(negedge clk);
        #2;
        check(13, bus_rdata, 32'h0000_0005);             // R13 one-clock latency
        vec_i = 32'h0000_0009;
        #1;
        check(13, bus_rdata, 32'h0000_0005);             // R13 not yet sampled
        @(negedge clk);
        vec_i = '1;
        bus_req = 1'b0;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            cap_i     = STEPS[i].cap;
            bus_req   = (STEPS[i].kind != K_IDLE);
            bus_we    = (STEPS[i].kind == K_WR);
            bus_addr  = STEPS[i].addr;
            bus_be    = STEPS[i].be;
            bus_wdata = STEPS[i].data;
            #2;
            if (STEPS[i].kind == K_RD) begin
                check(STEPS[i].rq, bus_rdata, STEPS[i].exp);
                check(12, 32'(bus_err), 32'(STEPS[i].err));   // R12
            end else if (STEPS[i].kind == K_WR) begin
                check(12, 32'(bus_err), 32'(STEPS[i].err));   // R12
            end
        end
        idle();
        #2;
        check(14, 32'(pend_o), 32'h0000_0010);           // R14
        check(9, 32'(master_en_o), 32'h0);               // R9
        access(1'b1, 5'h1C, 4'hF, 32'h0000_0001);
        idle();
        #2;
        check(9, 32'(master_en_o), 32'h1);               // R9
        access(1'b1, 5'h14, 4'hF, 32'h0000_0010);
        idle();
        #2;
        check(14, 32'(pend_o), 32'h0);                   // R14

        // reset clears the write-once bit
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 5'h1C, 4'hF, 32'h0);
        check(10, bus_rdata, 32'h0);                     // R10
        access(1'b1, 5'h00, 4'hF, 32'h0000_0008);
        access(1'b0, 5'h00, 4'hF, 32'h0);
        check(10, bus_rdata, 32'h0000_0008);             // R10 software path reopened
        idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R0 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule